// File: doc/BRIEF.md
# Programmable Event Counter Slice

This block is one general-purpose performance counter together with its own event-select register. Every clock it receives a set of event lanes, each carrying how many times that event occurred in the cycle, and a flag telling whether the processor currently runs in user or supervisor mode. The select register decides which lane is counted and in which privilege modes. It also holds an optional per-cycle threshold, which can be inverted or made edge-triggered, a local enable and an interrupt-on-wrap enable.

Software loads the select register and the count through two simple write-enable/data ports. The count is readable at any time as a plain output. When the count wraps past its maximum, the slice raises a one-cycle overflow pulse. An interrupt-request qualifier follows that pulse only when the select word allows it. A chip-level gate arrives as an input, so that a wider counter unit can start and stop many slices together.

Top module: `evt_ctr_slice`

## Requirements
- R1: Reset clears the select register, the count, the overflow pulse and the interrupt request to zero. With the select word at zero, no lane is counted.
- R2: The key in select bits 15:0 (qualifier byte in 15:8, event code in 7:0) is compared with each lane's 16-bit code. By default the codes are 0x0011, 0x0122, 0x0233 and 0x0344 for lanes 0 to 3. The increment of the matching lane is used. With no match, the count holds.
- R3: Counting requires select bit 22 (local enable) and the `global_en` input both high. Otherwise the count holds.
- R4: With `priv_user`=1, counting requires select bit 16. With `priv_user`=0, it requires select bit 17.
- R5: With a threshold (select bits 31:24) of zero, the raw lane increment (0 to 7 at default width) is added each cycle. The invert bit and the edge bit have no effect in this case.
- R6: With a nonzero threshold, the count adds 1 in a cycle where the lane increment is greater than or equal to the threshold, and adds 0 otherwise.
- R7: With a nonzero threshold and select bit 23 (invert) set, the count adds 1 in a cycle where the increment is below the threshold.
- R8: With a nonzero threshold and select bit 18 (edge) set, the count adds 1 only when the compare result is true in this cycle and was false in the previous cycle. The previous result is recorded on every clock and cleared by reset.
- R9: A count write loads the written data masked to the counter width. It takes priority over any event in the same cycle, and counting continues from the loaded value.
- R10: Count arithmetic is modulo 2^CNT_W. Preloading (1 - N) and then counting N single events gives a count of 1.
- R11: `ovf_pulse` is high for exactly the one cycle in which the count first shows a wrapped value. This holds whatever the value of select bit 20. A count write never raises it.
- R12: `irq_req` is high when `ovf_pulse` is high and select bit 20 is set, and low otherwise.
- R13: A select write takes effect for events from the cycle after the write. Events presented in the write cycle are counted under the old word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| global_en | input | 1 | Chip-level counting gate |
| priv_user | input | 1 | 1 = user mode, 0 = supervisor mode |
| evt_inc | input | NUM_EVT*INC_W | Per-lane event increments for this cycle, lane i at bits i*INC_W upward |
| sel_we | input | 1 | Select register write strobe |
| sel_wdata | input | 32 | Select register write data |
| cnt_we | input | 1 | Count write strobe |
| cnt_wdata | input | WD_W | Count write data, truncated to CNT_W |
| count | output | CNT_W | Current count |
| ovf_pulse | output | 1 | One-cycle wrap indication |
| irq_req | output | 1 | Wrap qualified by the interrupt enable |

## Verification
The bound checker watches several rules on every clock:
- a disabled, privilege-blocked or unmatched counter holds its value;
- a count write lands exactly one cycle later;
- a nonzero threshold never advances the count by more than one per cycle;
- an overflow pulse is single-cycle and coincides with a drop in the count.

The exact amounts added under thresholds, inversion and edge mode, the wrap arithmetic from a preload, the interrupt qualification and the one-cycle delay of a select write are shown only by the bench's directed scenarios. In those scenarios a scoreboard compares every cycle against a model built from the requirements.

// File: rtl/evc_pkg.sv
package evc_pkg;

  // Select word layout; field positions are decoded by software.
  typedef struct packed {
    logic [7:0] thresh;     // 31:24
    logic       invert;     // 23
    logic       enable;     // 22
    logic       spare;      // 21
    logic       irq_en;     // 20
    logic       pin_ctl;    // 19
    logic       edge_mode;  // 18
    logic       os_en;      // 17
    logic       usr_en;     // 16
    logic [7:0] qual;       // 15:8
    logic [7:0] code;       // 7:0
  } evsel_t;

  function automatic logic [15:0] sel_key(input evsel_t s);
    return {s.qual, s.code};
  endfunction

  function automatic logic priv_allows(input evsel_t s, input logic user_mode);
    return user_mode ? s.usr_en : s.os_en;
  endfunction

  function automatic logic thresh_cmp(input logic [7:0] inc, input logic [7:0] thr,
                                      input logic inv);
    return inv ? (inc < thr) : (inc >= thr);
  endfunction

endpackage

// File: rtl/evc_event_mux.sv
module evc_event_mux
  import evc_pkg::*;
#(
  parameter int NUM_EVT = 4,
  parameter int INC_W = 3,
  parameter logic [NUM_EVT*16-1:0] LANE_CODES = '0
) (
  input  logic [15:0]              key,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  output logic [INC_W-1:0]         inc,
  output logic                     hit
);
  logic [NUM_EVT-1:0] lane_match;

  for (genvar g = 0; g < NUM_EVT; g++) begin : g_lane
    assign lane_match[g] = (LANE_CODES[g*16 +: 16] == key);
  end

  // Lowest matching lane wins.
  always_comb begin
    inc = '0;
    hit = 1'b0;
    for (int i = NUM_EVT - 1; i >= 0; i--) begin
      if (lane_match[i]) begin
        inc = evt_inc[i*INC_W +: INC_W];
        hit = 1'b1;
      end
    end
  end
endmodule

// File: rtl/evc_qualify.sv
module evc_qualify
  import evc_pkg::*;
#(
  parameter int INC_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  evsel_t           sel,
  input  logic             priv_user,
  input  logic             global_en,
  input  logic             hit,
  input  logic [INC_W-1:0] inc,
  output logic             allow,
  output logic             cmp_now,
  output logic [INC_W-1:0] add_amt
);
  logic cmp_prev;
  logic qualified;
  logic [7:0] inc8;

  assign inc8    = 8'(inc);
  assign cmp_now = thresh_cmp(inc8, sel.thresh, sel.invert);
  assign allow   = sel.enable & global_en & priv_allows(sel, priv_user) & hit;
  assign qualified = sel.edge_mode ? (cmp_now & ~cmp_prev) : cmp_now;

  always_comb begin
    if (!allow)                  add_amt = '0;
    else if (sel.thresh == 8'd0) add_amt = inc;
    else                         add_amt = INC_W'(qualified);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp_prev <= 1'b0;
    else        cmp_prev <= cmp_now;
  end
endmodule

// File: rtl/evc_accum.sv
module evc_accum #(
  parameter int CNT_W = 48,
  parameter int INC_W = 3,
  parameter int WD_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [INC_W-1:0] add_amt,
  input  logic             wr_en,
  input  logic [WD_W-1:0]  wr_data,
  output logic [CNT_W-1:0] count,
  output logic             ovf_q,
  output logic             wrap_now
);
  localparam int SUM_W = CNT_W + 1;

  function automatic logic [SUM_W-1:0] widen_add(input logic [CNT_W-1:0] c,
                                                 input logic [INC_W-1:0] a);
    return {1'b0, c} + SUM_W'(a);
  endfunction

  logic [SUM_W-1:0] sum;

  assign sum      = widen_add(count, add_amt);
  assign wrap_now = ~wr_en & sum[CNT_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= wrap_now;
      count <= wr_en ? CNT_W'(wr_data) : sum[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/evt_ctr_slice.sv
module evt_ctr_slice
  import evc_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int INC_W = 3,
  parameter int NUM_EVT = 4,
  parameter int WD_W = 64,
  parameter logic [NUM_EVT*16-1:0] LANE_CODES = {16'h0344, 16'h0233, 16'h0122, 16'h0011}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     global_en,
  input  logic                     priv_user,
  input  logic [NUM_EVT*INC_W-1:0] evt_inc,
  input  logic                     sel_we,
  input  logic [31:0]              sel_wdata,
  input  logic                     cnt_we,
  input  logic [WD_W-1:0]          cnt_wdata,
  output logic [CNT_W-1:0]         count,
  output logic                     ovf_pulse,
  output logic                     irq_req
);
  evsel_t           sel_q;
  logic             ev_hit;
  logic [INC_W-1:0] ev_inc;
  logic [INC_W-1:0] add_amt;
  logic             cnt_allow;
  logic             cmp_now;
  logic             wrap_now;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_we) sel_q <= evsel_t'(sel_wdata);
  end

  evc_event_mux #(
    .NUM_EVT(NUM_EVT), .INC_W(INC_W), .LANE_CODES(LANE_CODES)
  ) u_mux (
    .key(sel_key(sel_q)), .evt_inc(evt_inc), .inc(ev_inc), .hit(ev_hit)
  );

  evc_qualify #(.INC_W(INC_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .sel(sel_q), .priv_user(priv_user),
    .global_en(global_en), .hit(ev_hit), .inc(ev_inc),
    .allow(cnt_allow), .cmp_now(cmp_now), .add_amt(add_amt)
  );

  evc_accum #(.CNT_W(CNT_W), .INC_W(INC_W), .WD_W(WD_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .add_amt(add_amt), .wr_en(cnt_we),
    .wr_data(cnt_wdata), .count(count), .ovf_q(ovf_pulse), .wrap_now(wrap_now)
  );

  assign irq_req = ovf_pulse & sel_q.irq_en;
endmodule

// File: rtl/evc_ctr_chk.sv
module evc_ctr_chk #(
  parameter int CNT_W = 48
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en_bit,
  input logic             usr_bit,
  input logic             os_bit,
  input logic [7:0]       thr,
  input logic             global_en,
  input logic             priv_user,
  input logic             ev_hit,
  input logic             cnt_we,
  input logic [CNT_W-1:0] cnt_wr_low,
  input logic [CNT_W-1:0] count,
  input logic             ovf_pulse
);
  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((!global_en || !en_bit) && !cnt_we) |=> (count == $past(count)) && !ovf_pulse);

  assert_priv_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((priv_user ? !usr_bit : !os_bit) && !cnt_we) |=> count == $past(count));

  assert_nomatch_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_hit && !cnt_we) |=> $stable(count));

  assert_write_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> (count == $past(cnt_wr_low)) && !ovf_pulse);

  assert_thresh_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((thr != 8'd0) && !cnt_we) |=> CNT_W'(count - $past(count)) <= CNT_W'(1));

  assert_ovf_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |=> !ovf_pulse);

  assert_ovf_wrapped_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (count < $past(count)) && !$past(cnt_we));
endmodule

bind evt_ctr_slice evc_ctr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_bit(sel_q.enable), .usr_bit(sel_q.usr_en),
  .os_bit(sel_q.os_en), .thr(sel_q.thresh), .global_en(global_en),
  .priv_user(priv_user), .ev_hit(ev_hit), .cnt_we(cnt_we),
  .cnt_wr_low(cnt_wdata[CNT_W-1:0]), .count(count), .ovf_pulse(ovf_pulse)
);

// File: tb/evt_ctr_slice_tb.sv
module evt_ctr_slice_tb;
  localparam int CW = 48;
  localparam logic [31:0] EN  = 32'h0040_0000;
  localparam logic [31:0] USR = 32'h0001_0000;
  localparam logic [31:0] OS  = 32'h0002_0000;
  localparam logic [31:0] EDG = 32'h0004_0000;
  localparam logic [31:0] IRQ = 32'h0010_0000;
  localparam logic [31:0] INV = 32'h0080_0000;
  localparam logic [31:0] TH2 = 32'h0200_0000;

  logic clk = 0, rst_n = 0, global_en = 0, priv_user = 0;
  logic [11:0] evt_inc = '0;
  logic sel_we = 0, cnt_we = 0;
  logic [31:0] sel_wdata = '0;
  logic [63:0] cnt_wdata = '0;
  logic [CW-1:0] count;
  logic ovf_pulse, irq_req;

  always #4 clk = ~clk;

  evt_ctr_slice u_dut (
    .clk(clk), .rst_n(rst_n), .global_en(global_en), .priv_user(priv_user),
    .evt_inc(evt_inc), .sel_we(sel_we), .sel_wdata(sel_wdata), .cnt_we(cnt_we),
    .cnt_wdata(cnt_wdata), .count(count), .ovf_pulse(ovf_pulse), .irq_req(irq_req)
  );

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [15:0] codes [4] = '{16'h0011, 16'h0122, 16'h0233, 16'h0344};

  // reference state
  logic [31:0] m_sel = '0;
  logic [CW-1:0] m_cnt = '0;
  logic m_prev = 0;

  logic [CW-1:0] q_cnt [$];
  logic q_ovf [$];
  logic q_irq [$];
  string q_tag [$];

  task automatic cmp(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per clock edge
  always @(posedge clk) begin
    #2;
    if (q_cnt.size() > 0) begin
      logic [CW-1:0] ec;
      logic eo, ei;
      string t;
      ec = q_cnt.pop_front(); eo = q_ovf.pop_front(); ei = q_irq.pop_front();
      t = q_tag.pop_front();
      cmp(t, "count", 64'(count), 64'(ec));
      cmp(t, "ovf", 64'(ovf_pulse), 64'(eo));
      cmp(t, "irq", 64'(irq_req), 64'(ei));
    end
  end

  function automatic logic [11:0] lanes(input int a, input int b, input int c, input int d);
    return {3'(d), 3'(c), 3'(b), 3'(a)};
  endfunction

  task automatic drive(input logic [11:0] incs, input logic usr, input logic gen,
                       input logic swe, input logic [31:0] sd, input logic cwe,
                       input logic [63:0] cd, input string tag);
    logic [2:0] inc;
    logic hit, c, ok, ov;
    logic [CW:0] tot;
    logic [2:0] add;
    @(negedge clk);
    evt_inc = incs; priv_user = usr; global_en = gen;
    sel_we = swe; sel_wdata = sd; cnt_we = cwe; cnt_wdata = cd;
    inc = '0; hit = 0;
    for (int i = 0; i < 4; i++)
      if (!hit && codes[i] == m_sel[15:0]) begin inc = incs[3*i +: 3]; hit = 1; end
    c = m_sel[23] ? (8'(inc) < m_sel[31:24]) : (8'(inc) >= m_sel[31:24]);
    ok = m_sel[22] && gen && (usr ? m_sel[16] : m_sel[17]) && hit;
    if (!ok) add = 0;
    else if (m_sel[31:24] == 0) add = inc;
    else add = (m_sel[18] ? (c && !m_prev) : c) ? 3'd1 : 3'd0;
    tot = {1'b0, m_cnt} + (CW+1)'(add);
    if (cwe) begin m_cnt = cd[CW-1:0]; ov = 0; end
    else begin m_cnt = tot[CW-1:0]; ov = tot[CW]; end
    m_prev = c;
    if (swe) m_sel = sd;
    q_cnt.push_back(m_cnt); q_ovf.push_back(ov);
    q_irq.push_back(ov && m_sel[20]); q_tag.push_back(tag);
  endtask

  task automatic run(input logic [11:0] incs, input logic usr, input logic gen, input string tag);
    drive(incs, usr, gen, 0, '0, 0, '0, tag);
  endtask
  task automatic set_sel(input logic [31:0] d, input string tag);
    drive('0, 1, 1, 1, d, 0, '0, tag);
  endtask
  task automatic set_cnt(input logic [63:0] d, input string tag);
    drive('0, 1, 1, 0, '0, 1, d, tag);
  endtask
  task automatic peek(input logic [CW-1:0] ec, input logic eo, input logic ei, input string tag);
    @(posedge clk); #3;
    cmp(tag, "direct count", 64'(count), 64'(ec));
    cmp(tag, "direct ovf", 64'(ovf_pulse), 64'(eo));
    cmp(tag, "direct irq", 64'(irq_req), 64'(ei));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    cmp("R1", "reset count", 64'(count), 0);
    cmp("R1", "reset ovf", 64'(ovf_pulse), 0);
    cmp("R1", "reset irq", 64'(irq_req), 0);
    @(negedge clk); rst_n = 1;
    run(lanes(7,7,7,7), 1, 1, "R1");
    run(lanes(7,7,7,7), 0, 1, "R1");
    peek(0, 0, 0, "R1");

    // R2 lane select
    set_sel(EN|USR|OS|32'h0122, "R2");
    set_cnt(0, "R2");
    for (int i = 0; i < 5; i++) run(lanes(7,2,7,7), 1, 1, "R2");
    peek(10, 0, 0, "R2");
    set_sel(EN|USR|OS|32'h0022, "R2");
    for (int i = 0; i < 3; i++) run(lanes(7,7,7,7), 1, 1, "R2");
    peek(10, 0, 0, "R2");
    set_sel(EN|USR|OS|32'h0344, "R2");
    for (int i = 0; i < 2; i++) run(lanes(1,1,1,4), 1, 1, "R2");
    peek(18, 0, 0, "R2");

    // R3 enables
    set_sel(USR|OS|32'h0011, "R3");
    for (int i = 0; i < 3; i++) run(lanes(5,0,0,0), 1, 1, "R3");
    peek(18, 0, 0, "R3");
    set_sel(EN|USR|OS|32'h0011, "R3");
    for (int i = 0; i < 3; i++) run(lanes(5,0,0,0), 1, 0, "R3");
    run(lanes(5,0,0,0), 1, 1, "R3");
    peek(23, 0, 0, "R3");

    // R4 privilege
    set_sel(EN|USR|32'h0011, "R4");
    run(lanes(5,0,0,0), 0, 1, "R4");
    run(lanes(5,0,0,0), 0, 1, "R4");
    run(lanes(5,0,0,0), 1, 1, "R4");
    peek(28, 0, 0, "R4");
    set_sel(EN|OS|32'h0011, "R4");
    run(lanes(5,0,0,0), 1, 1, "R4");
    run(lanes(5,0,0,0), 0, 1, "R4");
    peek(33, 0, 0, "R4");

    // R5 zero threshold ignores invert/edge
    set_sel(EN|USR|OS|INV|EDG|32'h0011, "R5");
    set_cnt(0, "R5");
    run(lanes(3,0,0,0), 1, 1, "R5");
    run(lanes(3,0,0,0), 1, 1, "R5");
    run(lanes(4,0,0,0), 1, 1, "R5");
    peek(10, 0, 0, "R5");

    // R6 threshold 2 (raw sum would be 9)
    set_sel(EN|USR|OS|TH2|32'h0011, "R6");
    set_cnt(0, "R6");
    foreach (codes[k]) begin end
    run(lanes(0,0,0,0), 1, 1, "R6"); run(lanes(1,0,0,0), 1, 1, "R6");
    run(lanes(2,0,0,0), 1, 1, "R6"); run(lanes(3,0,0,0), 1, 1, "R6");
    run(lanes(1,0,0,0), 1, 1, "R6"); run(lanes(2,0,0,0), 1, 1, "R6");
    peek(3, 0, 0, "R6");

    // R7 inverted threshold
    set_sel(EN|USR|OS|INV|TH2|32'h0011, "R7");
    set_cnt(0, "R7");
    run(lanes(0,0,0,0), 1, 1, "R7"); run(lanes(1,0,0,0), 1, 1, "R7");
    run(lanes(2,0,0,0), 1, 1, "R7"); run(lanes(3,0,0,0), 1, 1, "R7");
    run(lanes(1,0,0,0), 1, 1, "R7");
    peek(3, 0, 0, "R7");

    // R8 edge mode: compare pattern 1,1,0,1,1,1,0,1 -> 3 rises
    set_sel(EN|USR|OS|EDG|TH2|32'h0011, "R8");
    set_cnt(0, "R8");
    run(lanes(3,0,0,0), 1, 1, "R8"); run(lanes(3,0,0,0), 1, 1, "R8");
    run(lanes(0,0,0,0), 1, 1, "R8"); run(lanes(3,0,0,0), 1, 1, "R8");
    run(lanes(3,0,0,0), 1, 1, "R8"); run(lanes(3,0,0,0), 1, 1, "R8");
    run(lanes(0,0,0,0), 1, 1, "R8"); run(lanes(3,0,0,0), 1, 1, "R8");
    peek(3, 0, 0, "R8");

    // R9 write while running
    set_sel(EN|USR|OS|32'h0011, "R9");
    set_cnt(0, "R9");
    run(lanes(2,0,0,0), 1, 1, "R9"); run(lanes(2,0,0,0), 1, 1, "R9");
    drive(lanes(2,0,0,0), 1, 1, 0, '0, 1, 64'd100, "R9");
    run(lanes(2,0,0,0), 1, 1, "R9");
    peek(102, 0, 0, "R9");
    set_cnt(64'hAAAA_0000_0000_1234, "R9");
    peek(48'h1234, 0, 0, "R9");

    // R10 preload 1-N, N = 5
    set_cnt(64'hFFFF_FFFF_FFFF_FFFC, "R10");
    for (int i = 0; i < 5; i++) run(lanes(1,0,0,0), 1, 1, "R10");
    peek(1, 0, 0, "R10");

    // R11 overflow without interrupt enable
    set_cnt(64'hFFFF_FFFF_FFFF_FFFF, "R11");
    run(lanes(1,0,0,0), 1, 1, "R11");
    peek(0, 1, 0, "R11");
    run(lanes(0,0,0,0), 1, 1, "R11");
    peek(0, 0, 0, "R11");
    set_cnt(64'hFFFF_FFFF_FFFF, "R11");
    set_cnt(0, "R11");
    peek(0, 0, 0, "R11");
    set_cnt(64'hFFFF_FFFF_FFFE, "R11");
    run(lanes(7,0,0,0), 1, 1, "R11");
    peek(5, 1, 0, "R11");

    // R12 interrupt qualifier
    set_sel(EN|USR|OS|IRQ|32'h0011, "R12");
    set_cnt(64'hFFFF_FFFF_FFFF, "R12");
    run(lanes(1,0,0,0), 1, 1, "R12");
    peek(0, 1, 1, "R12");
    run(lanes(0,0,0,0), 1, 1, "R12");
    peek(0, 0, 0, "R12");

    // R13 select write timing
    set_sel(EN|USR|OS|32'h0011, "R13");
    set_cnt(0, "R13");
    drive(lanes(4,6,0,0), 1, 1, 1, EN|USR|OS|32'h0122, 0, '0, "R13");
    run(lanes(4,6,0,0), 1, 1, "R13");
    peek(10, 0, 0, "R13");

    repeat (3) @(posedge clk);
    #3;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule